// File: doc/BRIEF.md
# Cell Header Checker and Router

This block takes a byte stream of already-delineated fixed-size cells (53 bytes each: 5 header bytes, then 48 payload bytes) and decides the fate of each cell from its header. It holds the header until all five bytes have arrived. It then checks the header checksum byte, decodes the path and channel identifiers, and either forwards or discards the cell.

Cells that carry management traffic leave on a dedicated control port with their header intact. User data cells that match a connection entry leave on the fabric port, preceded by one routing tag byte that names the destination port. Cells with a corrupted header are discarded silently. Data cells with no matching connection are discarded and counted.

The header layout (user-side or network-side) is chosen by the `NNI` parameter. The connection table is a small register file with a single write port. All three byte streams use valid/ready handshakes. The default build is the user-side layout.

Top module: `atm_cell_hdr_proc`

## Requirements
- R1: After reset `in_ready` is 1, `fab_valid` and `ctl_valid` are 0, and `miss_count` is 0.
- R2: A cell whose header checksum byte (byte 4) is wrong produces no byte on either output, and all 53 of its bytes are consumed from the input.
- R3: The expected checksum is a CRC-8 with generator x^8+x^2+x+1 (0x07), initial value 0, processed MSB first over header bytes 0..3, then XORed with 0x55.
- R4: A forwarded data cell leaves the fabric port as 54 bytes: the tag byte, then header bytes 0..4, then the 48 payload bytes, all in arrival order. The control and fabric ports are never valid together.
- R5: In the user-side layout the fields are as follows. Byte0[7:4] is the flow-control field. The 8-bit path id is {byte0[3:0], byte1[7:4]}. The 16-bit channel id is {byte1[3:0], byte2, byte3[7:4]}. The 3-bit type is byte3[3:1], and the loss-priority bit is byte3[0]. The flow-control field has no effect on the lookup or on the tag.
- R6: A cell with a good checksum is a control cell when type bit 2 is 1, or when its channel id is at most `CTRL_VCI_MAX` (default 31). A control cell leaves on the control port as its 53 unmodified bytes, with no tag, and the table is not consulted.
- R7: A good, non-control cell with no valid matching table entry is discarded: no output byte is produced, and `miss_count` rises by exactly one (saturating).
- R8: No output byte of a cell is offered before its fifth header byte has been accepted.
- R9: An output byte that is offered but not taken stays valid and unchanged until it is taken.
- R10: A table write sets the entry's valid bit, path id, channel id and tag, and governs every cell whose header completes after the write. When several valid entries match, the lowest index supplies the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input cell byte |
| fab_valid | output | 1 | Fabric byte valid |
| fab_ready | input | 1 | Fabric can take a byte |
| fab_data | output | 8 | Fabric byte (tag, header, payload) |
| ctl_valid | output | 1 | Control-port byte valid |
| ctl_ready | input | 1 | Control processor can take a byte |
| ctl_data | output | 8 | Control-port byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(ENTRIES) | Table entry to write |
| tbl_vld | input | 1 | Valid bit for the written entry |
| tbl_vpi | input | 12 | Path id for the written entry |
| tbl_vci | input | 16 | Channel id for the written entry |
| tbl_tag | input | TAG_W | Output-port tag for the written entry |
| miss_count | output | MISS_W | Count of cells with no connection entry |

## Verification
The bench aims at the following cases:
- A corrupted checksum byte directly ahead of a good cell. A design that miscounts the dropped bytes loses alignment, and every later cell comes out wrong.
- Duplicate table entries, and an entry that is later invalidated. An inverted priority or a stale decision shows up as the wrong tag byte.
- Cells that differ only in the flow-control nibble. These expose a decoder that folds that nibble into the path id.
- Management cells addressed to a connected channel. These catch a design that lets the table override the control split.
- Long runs under random stalls on all three ports. These catch a byte that changes or vanishes while it waits, and any output that starts before the header is complete.

// File: rtl/atm_hdr_pkg.sv
package atm_hdr_pkg;
   localparam int HDR_BYTES = 5;
   localparam int VPI_W     = 12;
   localparam int VCI_W     = 16;

   typedef enum logic [1:0] {
      RT_DROP = 2'd0,
      RT_FAB  = 2'd1,
      RT_CTL  = 2'd2
   } route_e;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_DEC  = 2'd1,
      ST_EMIT = 2'd2,
      ST_PAY  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [3:0]       gfc;
      logic [VPI_W-1:0] vpi;
      logic [VCI_W-1:0] vci;
      logic [2:0]       pt;
      logic             clp;
   } cell_hdr_t;
endpackage

// File: rtl/atm_hec_check.sv
module atm_hec_check #(
   parameter int         DATA_BYTES = 4,
   parameter logic [7:0] POLY       = 8'h07,
   parameter logic [7:0] COSET      = 8'h55
) (
   input  logic [8*DATA_BYTES-1:0] hdr_bytes,
   input  logic [7:0]              rx_hec,
   output logic [7:0]              exp_hec,
   output logic                    hec_ok
);
   localparam int NBITS = 8 * DATA_BYTES;

   logic [7:0] crc;
   logic       fb;

   always_comb begin
      crc = '0;
      fb  = 1'b0;
      for (int i = NBITS - 1; i >= 0; i--) begin
         fb  = crc[7] ^ hdr_bytes[i];
         crc = {crc[6:0], 1'b0};
         if (fb) crc = crc ^ POLY;
      end
      exp_hec = crc ^ COSET;
   end

   assign hec_ok = (exp_hec == rx_hec);
endmodule

// File: rtl/atm_field_dec.sv
module atm_field_dec
   import atm_hdr_pkg::*;
#(
   parameter bit NNI = 1'b0
) (
   input  logic [31:0] hdr_bytes,
   output cell_hdr_t   fields
);
   logic [3:0]       gfc_w;
   logic [VPI_W-1:0] vpi_w;

   generate
      if (NNI) begin : g_nni
         assign gfc_w = 4'd0;
         assign vpi_w = hdr_bytes[31:20];
      end else begin : g_uni
         assign gfc_w = hdr_bytes[31:28];
         assign vpi_w = {4'd0, hdr_bytes[27:20]};
      end
   endgenerate

   always_comb begin
      fields.gfc = gfc_w;
      fields.vpi = vpi_w;
      fields.vci = hdr_bytes[19:4];
      fields.pt  = hdr_bytes[3:1];
      fields.clp = hdr_bytes[0];
   end
endmodule

// File: rtl/atm_vc_table.sv
module atm_vc_table
   import atm_hdr_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_vld,
   input  logic [VPI_W-1:0] wr_vpi,
   input  logic [VCI_W-1:0] wr_vci,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [VPI_W-1:0] look_vpi,
   input  logic [VCI_W-1:0] look_vci,
   output logic             hit,
   output logic [TAG_W-1:0] hit_tag
);
   logic             vld_q [ENTRIES];
   logic [VPI_W-1:0] vpi_q [ENTRIES];
   logic [VCI_W-1:0] vci_q [ENTRIES];
   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic [ENTRIES-1:0] match;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[e] <= 1'b0;
               vpi_q[e] <= '0;
               vci_q[e] <= '0;
               tag_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
               vld_q[e] <= wr_vld;
               vpi_q[e] <= wr_vpi;
               vci_q[e] <= wr_vci;
               tag_q[e] <= wr_tag;
            end
         end
         assign match[e] = vld_q[e] && (vpi_q[e] == look_vpi) && (vci_q[e] == look_vci);
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_tag = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit     = 1'b1;
            hit_tag = tag_q[i];
         end
      end
   end

   // R10: a write lands in the addressed entry on the next cycle
   p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_vld)) && (tag_q[$past(wr_idx)] == $past(wr_tag)))
      else $error("p_wr_lands_r10");
endmodule

// File: rtl/atm_cell_hdr_proc.sv
module atm_cell_hdr_proc
   import atm_hdr_pkg::*;
#(
   parameter bit NNI          = 1'b0,
   parameter int ENTRIES      = 8,
   parameter int TAG_W        = 8,
   parameter int PAY_BYTES    = 48,
   parameter int CTRL_VCI_MAX = 31,
   parameter int MISS_W       = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [7:0]                 in_data,
   output logic                       fab_valid,
   input  logic                       fab_ready,
   output logic [7:0]                 fab_data,
   output logic                       ctl_valid,
   input  logic                       ctl_ready,
   output logic [7:0]                 ctl_data,
   input  logic                       tbl_we,
   input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
   input  logic                       tbl_vld,
   input  logic [11:0]                tbl_vpi,
   input  logic [15:0]                tbl_vci,
   input  logic [TAG_W-1:0]           tbl_tag,
   output logic [MISS_W-1:0]          miss_count
);
   localparam int         IDX_W     = $clog2(ENTRIES);
   localparam int         PCNT_W    = $clog2(PAY_BYTES);
   localparam logic [2:0] HDR_LAST  = 3'(HDR_BYTES - 1);
   localparam logic [2:0] EMIT_LAST = 3'(HDR_BYTES);
   localparam logic [PCNT_W-1:0] PAY_LAST = PCNT_W'(PAY_BYTES - 1);
   localparam logic [VCI_W-1:0]  CTRL_MAX = VCI_W'(CTRL_VCI_MAX);

   generate
      if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag
         $error("TAG_W must fit in one byte");
      end
      if (ENTRIES < 2) begin : g_bad_ent
         $error("ENTRIES must be at least 2");
      end
      if (PAY_BYTES < 2) begin : g_bad_pay
         $error("PAY_BYTES must be at least 2");
      end
      if (MISS_W < 1) begin : g_bad_miss
         $error("MISS_W must be positive");
      end
   endgenerate

   phase_e            phase_q;
   route_e            route_q, route_d;
   logic [7:0]        hdr_q [HDR_BYTES];
   logic [2:0]        hcnt_q;
   logic [2:0]        ecnt_q;
   logic [PCNT_W-1:0] pcnt_q;
   logic [7:0]        tag_q;
   logic [MISS_W-1:0] miss_q;
   logic              miss_d;

   logic [31:0]       hdr_word;
   logic [7:0]        exp_hec;
   logic              hec_ok;
   cell_hdr_t         fields;
   logic              is_ctl;
   logic              hit;
   logic [TAG_W-1:0]  hit_tag;
   logic              sel_ready;
   logic [7:0]        out_byte;

   assign hdr_word = {hdr_q[0], hdr_q[1], hdr_q[2], hdr_q[3]};

   atm_hec_check #(.DATA_BYTES(4), .POLY(8'h07), .COSET(8'h55)) u_hec (
      .hdr_bytes (hdr_word),
      .rx_hec    (hdr_q[4]),
      .exp_hec   (exp_hec),
      .hec_ok    (hec_ok)
   );

   atm_field_dec #(.NNI(NNI)) u_dec (
      .hdr_bytes (hdr_word),
      .fields    (fields)
   );

   atm_vc_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_idx   (tbl_idx),
      .wr_vld   (tbl_vld),
      .wr_vpi   (tbl_vpi),
      .wr_vci   (tbl_vci),
      .wr_tag   (tbl_tag),
      .look_vpi (fields.vpi),
      .look_vci (fields.vci),
      .hit      (hit),
      .hit_tag  (hit_tag)
   );

   // decision on a completed header
   assign is_ctl = fields.pt[2] || (fields.vci <= CTRL_MAX);

   always_comb begin
      route_d = RT_DROP;
      miss_d  = 1'b0;
      if (hec_ok) begin
         if (is_ctl)   route_d = RT_CTL;
         else if (hit) route_d = RT_FAB;
         else          miss_d  = 1'b1;
      end
   end

   // output and input-side steering
   always_comb begin
      fab_valid = 1'b0;
      ctl_valid = 1'b0;
      in_ready  = 1'b0;
      out_byte  = 8'h00;
      sel_ready = (route_q == RT_FAB) ? fab_ready : ctl_ready;
      unique case (phase_q)
         ST_HDR:  in_ready = 1'b1;
         ST_DEC:  ;
         ST_EMIT: begin
            out_byte  = (ecnt_q == 3'd0) ? tag_q : hdr_q[ecnt_q - 3'd1];
            fab_valid = (route_q == RT_FAB);
            ctl_valid = (route_q == RT_CTL);
         end
         ST_PAY: begin
            out_byte = in_data;
            if (route_q == RT_DROP) begin
               in_ready = 1'b1;
            end else begin
               in_ready  = sel_ready;
               fab_valid = in_valid && (route_q == RT_FAB);
               ctl_valid = in_valid && (route_q == RT_CTL);
            end
         end
         default: ;
      endcase
   end

   assign fab_data   = out_byte;
   assign ctl_data   = out_byte;
   assign miss_count = miss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_HDR;
         route_q <= RT_DROP;
         hcnt_q  <= '0;
         ecnt_q  <= '0;
         pcnt_q  <= '0;
         tag_q   <= '0;
         miss_q  <= '0;
         for (int b = 0; b < HDR_BYTES; b++) hdr_q[b] <= '0;
      end else begin
         unique case (phase_q)
            ST_HDR: begin
               if (in_valid) begin
                  hdr_q[hcnt_q] <= in_data;
                  if (hcnt_q == HDR_LAST) begin
                     hcnt_q  <= '0;
                     phase_q <= ST_DEC;
                  end else begin
                     hcnt_q <= hcnt_q + 3'd1;
                  end
               end
            end
            ST_DEC: begin
               route_q <= route_d;
               tag_q   <= 8'(hit_tag);
               ecnt_q  <= (route_d == RT_FAB) ? 3'd0 : 3'd1;
               pcnt_q  <= '0;
               phase_q <= (route_d == RT_DROP) ? ST_PAY : ST_EMIT;
               if (miss_d && (miss_q != '1)) miss_q <= miss_q + 1'b1;
            end
            ST_EMIT: begin
               if (sel_ready) begin
                  if (ecnt_q == EMIT_LAST) phase_q <= ST_PAY;
                  else                     ecnt_q  <= ecnt_q + 3'd1;
               end
            end
            ST_PAY: begin
               if (in_valid && in_ready) begin
                  if (pcnt_q == PAY_LAST) phase_q <= ST_HDR;
                  else                    pcnt_q  <= pcnt_q + 1'b1;
               end
            end
            default: phase_q <= ST_HDR;
         endcase
      end
   end

   // R9: a stalled byte stays put
   p_hold_fab_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_valid && !fab_ready) |=> (fab_valid && $stable(fab_data)))
      else $error("p_hold_fab_r9");
   p_hold_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data)))
      else $error("p_hold_ctl_r9");

   // R4: the two output ports never both offer a byte
   p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fab_valid && ctl_valid))
      else $error("p_one_port_r4");

   // R2: a failed checksum yields silence on both ports
   p_bad_hec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_DEC && !hec_ok) |=> (!fab_valid && !ctl_valid))
      else $error("p_bad_hec_r2");

   // R7: the miss counter moves by at most one per cycle
   p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((miss_q - $past(miss_q)) <= MISS_W'(1)))
      else $error("p_miss_step_r7");

   // R8: nothing leaves while a header is still arriving
   p_no_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_HDR) |-> (!fab_valid && !ctl_valid))
      else $error("p_no_early_r8");
endmodule

// File: tb/sim_atm_cell_hdr_proc.sv
module sim_atm_cell_hdr_proc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ready;
   logic [7:0]  in_data = 8'h00;
   logic        fab_valid, fab_ready = 1'b1;
   logic [7:0]  fab_data;
   logic        ctl_valid, ctl_ready = 1'b1;
   logic [7:0]  ctl_data;
   logic        tbl_we = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic        tbl_vld = 1'b0;
   logic [11:0] tbl_vpi = '0;
   logic [15:0] tbl_vci = '0;
   logic [7:0]  tbl_tag = '0;
   logic [15:0] miss_count;

   always #5 clk = ~clk;

   atm_cell_hdr_proc u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_data(fab_data),
      .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_vld(tbl_vld),
      .tbl_vpi(tbl_vpi), .tbl_vci(tbl_vci), .tbl_tag(tbl_tag),
      .miss_count(miss_count)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] in_q[$];
   logic [7:0] fab_q[$];
   logic [7:0] ctl_q[$];
   string      fab_rq[$];
   string      ctl_rq[$];
   bit         m_vld [8];
   logic [11:0] m_vpi [8];
   logic [15:0] m_vci [8];
   logic [7:0]  m_tag [8];
   int  m_miss = 0;
   bit  rnd_mode = 1'b0;
   bit  hold = 1'b0;
   int  cell_pos = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_hec(logic [31:0] d);
      logic [7:0] c = 8'h00;
      for (int k = 31; k >= 0; k--) begin
         logic top = c[7] ^ d[k];
         c = c << 1;
         if (top) c = c ^ 8'h07;
      end
      return c ^ 8'h55;
   endfunction

   // reference model: one cell in, expected bytes out
   task automatic send_cell(logic [3:0] gfc, logic [11:0] vpi, logic [15:0] vci,
                            logic [2:0] pt, logic clp, bit bad, logic [7:0] seed, string tag_req);
      logic [7:0] h [5];
      logic [7:0] p [48];
      int hit_i = -1;
      h[0] = {gfc, vpi[7:4]};
      h[1] = {vpi[3:0], vci[15:12]};
      h[2] = vci[11:4];
      h[3] = {vci[3:0], pt, clp};
      h[4] = ref_hec({h[0], h[1], h[2], h[3]}) ^ (bad ? (8'h01 << (seed % 8)) : 8'h00);
      for (int i = 0; i < 48; i++) p[i] = 8'(seed + i * 3);
      for (int i = 0; i < 5; i++) in_q.push_back(h[i]);
      for (int i = 0; i < 48; i++) in_q.push_back(p[i]);
      if (bad) return;
      if (pt[2] || vci <= 16'd31) begin
         for (int i = 0; i < 5; i++) begin ctl_q.push_back(h[i]); ctl_rq.push_back("R6"); end
         for (int i = 0; i < 48; i++) begin ctl_q.push_back(p[i]); ctl_rq.push_back("R6"); end
         return;
      end
      for (int e = 7; e >= 0; e--)
         if (m_vld[e] && m_vpi[e] == {4'd0, vpi[7:0]} && m_vci[e] == vci) hit_i = e;
      if (hit_i < 0) begin
         m_miss++;
         return;
      end
      fab_q.push_back(m_tag[hit_i]); fab_rq.push_back(tag_req);
      for (int i = 0; i < 5; i++) begin fab_q.push_back(h[i]); fab_rq.push_back("R3"); end
      for (int i = 0; i < 48; i++) begin fab_q.push_back(p[i]); fab_rq.push_back("R4"); end
   endtask

   task automatic drain();
      wait (in_q.size() == 0 && fab_q.size() == 0 && ctl_q.size() == 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic tbl_write(int idx, bit vld, logic [11:0] vpi, logic [15:0] vci, logic [7:0] tag);
      drain();
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_vld = vld;
      tbl_vpi = vpi; tbl_vci = vci; tbl_tag = tag;
      @(negedge clk);
      tbl_we = 1'b0;
      m_vld[idx] = vld; m_vpi[idx] = vpi; m_vci[idx] = vci; m_tag[idx] = tag;
   endtask

   // per-cycle driver and comparator, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (!hold) in_valid = (in_q.size() > 0) && (!rnd_mode || ($urandom % 4 != 0));
         in_data   = (in_q.size() > 0) ? in_q[0] : 8'h00;
         fab_ready = !rnd_mode || ($urandom % 3 != 0);
         ctl_ready = !rnd_mode || ($urandom % 3 != 0);
         #1;
         if (cell_pos < 5 && (fab_valid || ctl_valid))
            chk("R8", "output during header", 1, 0);
         if (fab_valid && fab_ready) begin
            if (fab_q.size() == 0) chk("R8", "unexpected fab byte", {24'd0, fab_data}, 32'hFFFF_FFFF);
            else chk(fab_rq.pop_front(), "fab byte", {24'd0, fab_data}, {24'd0, fab_q.pop_front()});
         end
         if (ctl_valid && ctl_ready) begin
            if (ctl_q.size() == 0) chk("R6", "unexpected ctl byte", {24'd0, ctl_data}, 32'hFFFF_FFFF);
            else chk(ctl_rq.pop_front(), "ctl byte", {24'd0, ctl_data}, {24'd0, ctl_q.pop_front()});
         end
         hold = in_valid && !in_ready;
         if (in_valid && in_ready) begin
            void'(in_q.pop_front());
            cell_pos = (cell_pos == 52) ? 0 : cell_pos + 1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int e = 0; e < 8; e++) begin m_vld[e] = 0; m_vpi[e] = 0; m_vci[e] = 0; m_tag[e] = 0; end
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "in_ready in reset", {31'd0, in_ready}, 1);
      chk("R1", "fab_valid in reset", {31'd0, fab_valid}, 0);
      chk("R1", "ctl_valid in reset", {31'd0, ctl_valid}, 0);
      chk("R1", "miss_count in reset", {16'd0, miss_count}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      tbl_write(0, 1, 12'd5, 16'd100, 8'd3);
      tbl_write(1, 1, 12'd5, 16'd100, 8'd9);
      tbl_write(2, 1, 12'h2A, 16'h1234, 8'd7);
      tbl_write(3, 0, 12'd7, 16'd200, 8'd4);

      // R10: duplicate entries, lowest index wins
      send_cell(4'h0, 12'd5, 16'd100, 3'd0, 1'b0, 0, 8'h10, "R10");
      // R5: flow-control nibble ignored
      send_cell(4'hF, 12'd5, 16'd100, 3'd1, 1'b0, 0, 8'h20, "R5");
      // R3: other fields, loss-priority bit set
      send_cell(4'h6, 12'h2A, 16'h1234, 3'd0, 1'b1, 0, 8'h30, "R3");
      // R2: bad checksum, then a good cell must stay aligned
      send_cell(4'h0, 12'd5, 16'd100, 3'd0, 1'b0, 1, 8'h41, "R2");
      send_cell(4'h0, 12'h2A, 16'h1234, 3'd0, 1'b0, 0, 8'h50, "R2");
      drain();
      chk("R2", "input consumed", in_q.size(), 0);
      chk("R7", "miss after good cells", {16'd0, miss_count}, m_miss);

      // R6: low channel id and management type both go to control port
      send_cell(4'h0, 12'd0, 16'd5, 3'd0, 1'b0, 0, 8'h60, "R6");
      send_cell(4'h0, 12'd5, 16'd100, 3'd4, 1'b0, 0, 8'h70, "R6");
      send_cell(4'h0, 12'd9, 16'd31, 3'd0, 1'b0, 0, 8'h71, "R6");
      // R7: invalid entry and unknown pair are misses
      send_cell(4'h0, 12'd7, 16'd200, 3'd0, 1'b0, 0, 8'h80, "R7");
      send_cell(4'h0, 12'd9, 16'd999, 3'd0, 1'b0, 0, 8'h90, "R7");
      send_cell(4'h0, 12'd9, 16'd32, 3'd0, 1'b0, 0, 8'h91, "R7");
      drain();
      chk("R7", "miss count", {16'd0, miss_count}, m_miss);
      chk("R7", "three misses", m_miss, 3);

      // R10: invalidate entry 0, entry 1 now supplies the tag
      tbl_write(0, 0, 12'd5, 16'd100, 8'd3);
      send_cell(4'h0, 12'd5, 16'd100, 3'd0, 1'b0, 0, 8'hA0, "R10");
      drain();
      tbl_write(3, 1, 12'd7, 16'd200, 8'd11);
      send_cell(4'h0, 12'd7, 16'd200, 3'd2, 1'b0, 0, 8'hB0, "R10");
      drain();

      // R9: random stalls on all ports, mixed traffic
      rnd_mode = 1'b1;
      for (int c = 0; c < 24; c++) begin
         case (c % 6)
            0: send_cell(4'(c), 12'd5, 16'd100, 3'd0, 1'b0, 0, 8'(c * 11), "R9");
            1: send_cell(4'h0, 12'h2A, 16'h1234, 3'd1, 1'(c), 0, 8'(c * 13), "R9");
            2: send_cell(4'h0, 12'd5, 16'd100, 3'd0, 1'b0, 1, 8'(c * 5), "R2");
            3: send_cell(4'h0, 12'd0, 16'(c), 3'd0, 1'b0, 0, 8'(c * 7), "R6");
            4: send_cell(4'h0, 12'd3, 16'd4000, 3'd0, 1'b0, 0, 8'(c), "R7");
            default: send_cell(4'h0, 12'd7, 16'd200, 3'd5, 1'b0, 0, 8'(c * 17), "R6");
         endcase
      end
      drain();
      chk("R7", "miss after stress", {16'd0, miss_count}, m_miss);
      chk("R9", "all input taken", in_q.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule